// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one global history register that records the outcomes of recent branches, one bit per branch. It also keeps a table of 2-bit saturating counters. To look up a branch, the block combines its instruction address bits with the history by bitwise XOR and uses the result as the table row. Two branches that see the same history pattern therefore usually land in different rows.

A fetch stage uses the predict channel. It presents a branch address and gets back a direction and the table row that was used, both in the same cycle. The row is carried down the pipeline with the branch. When the branch resolves, the update channel returns that row together with the real outcome. The block then trains the counter in that row and shifts the outcome into the history.

Both channels use valid/ready. Both ready outputs stay high at all times, so the block never applies back-pressure: a beat transfers in every cycle in which its valid is high. A prediction is combinational and always reads the state as it stood before any update accepted in the same cycle. That update takes effect at the next clock edge.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds 01 (weakly not taken). As a result, every prediction made before the first update is not-taken, and the reported row equals address bits [13:2].
- R2: The reported row `prd_index` is address bits [13:2] XOR the 12-bit history. It is valid combinationally, in the same cycle as the request.
- R3: `prd_taken` is bit 1 (the upper bit) of the counter in the reported row while `prd_valid` is high, and 0 while `prd_valid` is low. Counter encoding: 11 strong taken, 10 weak taken, 01 weak not-taken, 00 strong not-taken.
- R4: An accepted update with `upd_taken`=1 increments the counter in row `upd_index`. A counter already at 11 stays at 11.
- R5: An accepted update with `upd_taken`=0 decrements the counter in row `upd_index`. A counter already at 00 stays at 00.
- R6: An accepted update shifts the history left by one, with the outcome (1 for taken, 0 for not-taken) entering bit 0. The new history is visible in `prd_index` from the next cycle.
- R7: Training uses the row supplied on `upd_index`, not the row the current history would select for that branch.
- R8: In a cycle with `upd_valid` low, neither the history nor any counter changes. `prd_ready` and `upd_ready` are always 1.
- R9: A prediction made in the same cycle as an accepted update reflects the state from before that update.
- R10: A branch that always trains one row with the repeating outcome sequence T T T N is mispredicted only on the N once warmed up, which gives 75% accuracy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| prd_valid | input | 1 | Prediction request present |
| prd_ready | output | 1 | Always 1; a request is never stalled |
| prd_pc | input | 32 | Branch instruction address |
| prd_taken | output | 1 | Predicted direction, 1 = taken |
| prd_index | output | 12 | Table row used for this prediction |
| upd_valid | input | 1 | Resolved-branch update present |
| upd_ready | output | 1 | Always 1; an update is never stalled |
| upd_index | input | 12 | Row recorded at prediction time |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The assertions assume that `upd_taken` and `upd_index` are known whenever `upd_valid` is high, and that the update channel is driven only after reset has been released. The bench changes inputs only on the falling edge and keeps each update's fields stable through the following rising edge. It draws update rows both from earlier predictions and from free random values, so the assertions see training at rows the history no longer points to. Its branch addresses come from a small pool, so counters reach both saturation limits, and the mixed random phase produces cycles with a prediction alone, an update alone, both, or neither.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // saturating step toward the observed outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_STRONG_NT) ? cur : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/gs_history.sv
module gs_history #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
  end

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));

  // R6
  hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[0] == $past(shift_bit));
endmodule

// File: rtl/gs_index.sv
module gs_index #(
  parameter int IDX_W = 12
) (
  input  logic [IDX_W-1:0] pc_bits,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);
  always_comb idx = pc_bits ^ hist;
endmodule

// File: rtl/gs_pht.sv
module gs_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
    end
  end

  always_comb rd_ctr = tbl[rd_idx];

  // R4
  taken_leaves_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken) |=> tbl[$past(wr_idx)] != CTR_STRONG_NT);

  // R5
  nottaken_leaves_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken) |=> tbl[$past(wr_idx)] != CTR_STRONG_T);
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 12,
  parameter int ALIGN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_valid,
  output logic             prd_ready,
  input  logic [PC_W-1:0]  prd_pc,
  output logic             prd_taken,
  output logic [IDX_W-1:0] prd_index,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [IDX_W-1:0] upd_index,
  input  logic             upd_taken
);
  localparam int PC_LO = ALIGN;
  localparam int PC_HI = ALIGN + IDX_W - 1;

  logic [IDX_W-1:0] hist;
  logic [IDX_W-1:0] look_idx;
  ctr_t             look_ctr;
  logic             upd_fire;
  logic             unused_pc_bits;

  assign prd_ready      = 1'b1;
  assign upd_ready      = 1'b1;
  assign upd_fire       = upd_valid & upd_ready;
  assign unused_pc_bits = ^{prd_pc[PC_W-1:PC_HI+1], prd_pc[PC_LO-1:0]};

  gs_history #(.HIST_W(IDX_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (upd_fire),
    .shift_bit (upd_taken),
    .hist      (hist)
  );

  gs_index #(.IDX_W(IDX_W)) u_index (
    .pc_bits (prd_pc[PC_HI:PC_LO]),
    .hist    (hist),
    .idx     (look_idx)
  );

  gs_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (look_idx),
    .rd_ctr   (look_ctr),
    .wr_en    (upd_fire),
    .wr_idx   (upd_index),
    .wr_taken (upd_taken)
  );

  assign prd_index = look_idx;
  assign prd_taken = prd_valid & ctr_dir(look_ctr);

  // R8
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_ready && upd_ready);

  // R3
  idle_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prd_valid |-> !prd_taken);
endmodule

// File: tb/tb_gshare_predictor.sv
module tb_gshare_predictor;
  localparam int IDX_W = 12;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prd_valid = 1'b0;
  logic prd_ready;
  logic [31:0] prd_pc = '0;
  logic prd_taken;
  logic [IDX_W-1:0] prd_index;
  logic upd_valid = 1'b0;
  logic upd_ready;
  logic [IDX_W-1:0] upd_index = '0;
  logic upd_taken = 1'b0;

  always #10 clk = ~clk;

  gshare_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .prd_valid(prd_valid), .prd_ready(prd_ready), .prd_pc(prd_pc),
    .prd_taken(prd_taken), .prd_index(prd_index),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_index(upd_index), .upd_taken(upd_taken)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [1:0] mdl_tbl [DEPTH];
  logic [IDX_W-1:0] mdl_hist;

  function automatic logic [1:0] mdl_step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    else   return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic [31:0] pc_for_row(input logic [IDX_W-1:0] row);
    return {18'h0, row ^ mdl_hist, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check outputs, then retire into the model
  task automatic cycle(input logic pv, input logic [31:0] ppc,
                       input logic uv, input logic [IDX_W-1:0] uidx, input logic ut,
                       input string tag, output logic got_taken);
    logic [IDX_W-1:0] e_idx;
    @(negedge clk);
    prd_valid = pv; prd_pc = ppc;
    upd_valid = uv; upd_index = uidx; upd_taken = ut;
    #2;
    e_idx = ppc[13:2] ^ mdl_hist;
    got_taken = prd_taken;
    check({tag, " index R2"}, 32'(prd_index), 32'(e_idx));
    check({tag, " dir R3"}, 32'(prd_taken), 32'(pv & mdl_tbl[e_idx][1]));
    check("ready R8", {30'h0, prd_ready, upd_ready}, 32'h3);
    @(posedge clk);
    #1;
    if (uv) begin
      mdl_tbl[uidx] = mdl_step(mdl_tbl[uidx], ut);
      mdl_hist = {mdl_hist[IDX_W-2:0], ut};
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R8 actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic t;
    logic [IDX_W-1:0] row;
    logic [31:0] pool [8];
    logic [IDX_W-1:0] last_idx [4];
    int miss;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) mdl_tbl[i] = 2'b01;
    mdl_hist = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, several addresses
    cycle(1, 32'h0000_1234, 0, '0, 0, "reset R1", t);
    cycle(1, 32'hFFFF_FFFC, 0, '0, 0, "reset R1", t);
    check("reset dir R1", 32'(t), 0);
    cycle(1, 32'h0000_3FF8, 0, '0, 0, "reset R1", t);

    // R4/R5 saturation on row 5: four takens, then not-takens
    for (int k = 0; k < 4; k++) cycle(0, 0, 1, 12'd5, 1, "sat R4", t);
    cycle(1, pc_for_row(12'd5), 0, '0, 0, "sat R4", t);
    check("saturate high R4", 32'(t), 1);
    cycle(0, 0, 1, 12'd5, 0, "sat R5", t);
    cycle(1, pc_for_row(12'd5), 0, '0, 0, "sat R5", t);
    check("one down still taken R4", 32'(t), 1);
    cycle(0, 0, 1, 12'd5, 0, "sat R5", t);
    cycle(1, pc_for_row(12'd5), 0, '0, 0, "sat R5", t);
    check("two down not taken R5", 32'(t), 0);
    for (int k = 0; k < 4; k++) cycle(0, 0, 1, 12'd5, 0, "sat R5", t);
    cycle(0, 0, 1, 12'd5, 1, "sat R5", t);
    cycle(1, pc_for_row(12'd5), 0, '0, 0, "sat R5", t);
    check("floor then one up R5", 32'(t), 0);

    // R6: history shift seen through the index with address zero
    cycle(0, 0, 1, 12'd9, 1, "hist R6", t);
    cycle(1, 0, 0, '0, 0, "hist R6", t);
    check("history bit0 R6", 32'(prd_index[0]), 1);

    // R7: train a row unrelated to the current history
    row = 12'hABC;
    cycle(0, 0, 1, row, 1, "row R7", t);
    cycle(0, 0, 1, row, 1, "row R7", t);
    cycle(1, pc_for_row(row), 0, '0, 0, "row R7", t);
    check("supplied row trained R7", 32'(t), 1);

    // R8: idle cycles change nothing
    for (int k = 0; k < 5; k++) cycle(1, pc_for_row(row), 0, 12'h123, 0, "idle R8", t);
    check("idle keeps counter R8", 32'(t), 1);

    // R9: predict and update the same row in one cycle
    cycle(1, pc_for_row(row), 1, row, 0, "same R9", t);
    check("pre-update view R9", 32'(t), 1);

    // R10: T T T N on one row
    row = 12'h077;
    miss = 0;
    for (int rep = 0; rep < 6; rep++) begin
      for (int k = 0; k < 4; k++) begin
        logic o;
        o = (k != 3);
        cycle(1, pc_for_row(row), 1, row, o, "loop R10", t);
        if (rep >= 2 && t != o) miss++;
      end
    end
    check("TTTN misses R10", 32'(miss), 4);

    // random mix
    for (int i = 0; i < 8; i++) pool[i] = $urandom() & 32'h0000_3FFC;
    for (int i = 0; i < 4; i++) last_idx[i] = '0;
    for (int n = 0; n < 3000; n++) begin
      logic pv, uv, ut;
      logic [31:0] pc;
      logic [IDX_W-1:0] ui;
      pv = ($urandom() % 4) != 0;
      uv = ($urandom() % 3) != 0;
      ut = ($urandom() % 4) != 0;
      pc = pool[$urandom() % 8];
      ui = (($urandom() % 4) == 0) ? IDX_W'($urandom()) : last_idx[$urandom() % 4];
      if (pv) last_idx[n % 4] = pc[13:2] ^ mdl_hist;
      cycle(pv, pc, uv, ui, ut, uv ? (pv ? "rand R9" : "rand R4 R5 R6 R7") : "rand R8", t);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule